// File: doc/BRIEF.md
# Amplifier Mode and Start-up Sequencer

This block sequences the power-up and power-down of a two-channel switching audio amplifier. A decoded mode request selects one of three levels: standby (power stage idle, lowest current), mute (power stage switching with the audio held off) and operate (audio passes). The block drives three outputs: the power-stage switching enable, the audio release enable and a standby indication. All delays are counted in strobes of a 1 ms timebase tick.

When the request leaves standby, a start-up delay runs before the power stage may switch. During that delay an output check reports, for each output terminal, whether it is shorted to the positive or the negative supply. Any reported short freezes the delay until every output reads open again. Once switching runs, the check no longer has any effect. Audio is released only under two conditions: operate must be requested, and the amplifier must have been muted for a minimum time. That minimum is the start-up delay plus a second, shorter delay. A direct request for operate from standby therefore gives switching after the first delay and audio after the second. A request for standby at any point shuts everything down at once.

Top module: `amp_seq`

## Requirements
- R1: A synchronous active-high reset leaves the block in standby: sw_en = 0, audio_en = 0, standby_ind = 1.
- R2: mode_req encodes 2'b00 = standby, 2'b01 = mute, 2'b10 or 2'b11 = operate. A non-standby request seen while in standby clears standby_ind on the next clock.
- R3: After standby is left, sw_en rises on the clock edge at which the T_SW-th counted tick is taken (default 100). Ticks seen while in standby are not counted.
- R4: Bit 2k of short_flags reports output k shorted to the positive supply, and bit 2k+1 reports it shorted to the negative supply. The flags pass through SYNC_STAGES flip-flops. While any synchronized flag is set during the start-up delay, ticks are not counted, so switching is delayed by exactly the stalled ticks.
- R5: Once sw_en is high, short_flags have no effect. Switching stays on for as long as standby is not requested.
- R6: audio_en rises one clock after both of these hold: operate is requested, and T_SW+T_AUD ticks (default 150) have been counted since mute was entered.
- R7: After a direct request from standby to operate, audio_en rises one clock after the (T_SW+T_AUD)-th tick.
- R8: A mute request while audio plays clears audio_en on the next clock and keeps sw_en high. The mute timer restarts from zero, so a later operate request needs T_SW+T_AUD more ticks.
- R9: A standby request in any state clears sw_en and audio_en and sets standby_ind on the next clock. It also resets the delay count.
- R10: audio_en is never high while sw_en is low.
- R11: The delay counter saturates at T_SW+T_AUD and never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Decoded mode request (00 standby, 01 mute, 1x operate) |
| tick | input | 1 | One-clock strobe every 1 ms |
| short_flags | input | 2*NOUT | Per-output short flags; bit 2k = to positive supply, bit 2k+1 = to negative supply |
| sw_en | output | 1 | Power-stage switching enable |
| audio_en | output | 1 | Audio release enable |
| standby_ind | output | 1 | High while in standby |

## Verification
The bound checker checks the following on every cycle:
- a standby request shuts everything off one clock later;
- standby is left one clock after a non-standby request;
- audio never runs without switching;
- audio drops on a mute request without stopping switching;
- switching, once on, ignores the short flags;
- switching starts only on a tick;
- audio starts only under an operate request with the count saturated;
- the counter never exceeds its limit.

The exact tick at which switching and audio start can only be shown by the bench's sweeps. The same holds for the stall length caused by a short on each flag bit at each point of the delay, and for the restart of the mute timer after operate falls back to mute.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ARM   = 2'd1,
      SEQ_MUTED = 2'd2,
      SEQ_LIVE  = 2'd3
   } seq_state_t;

   function automatic logic req_is_stby(input logic [1:0] m);
      return (m == 2'b00);
   endfunction

   function automatic logic req_is_oper(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/amp_seq_shortmon.sv
module amp_seq_shortmon #(
   parameter int NOUT        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2*NOUT-1:0] flags,
   output logic              short_any
);
   localparam int FW = 2 * NOUT;

   logic [FW-1:0]   flags_s;
   logic [NOUT-1:0] out_fault;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign flags_s = flags;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][FW-1:0] pipe;
         always_ff @(posedge clk) begin
            if (rst) begin
               pipe <= '0;
            end else begin
               pipe[0] <= flags;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  pipe[i] <= pipe[i-1];
               end
            end
         end
         assign flags_s = pipe[SYNC_STAGES-1];
      end

      for (genvar k = 0; k < NOUT; k++) begin : g_out
         assign out_fault[k] = flags_s[2*k] | flags_s[2*k+1];
      end
   endgenerate

   assign short_any = |out_fault;

endmodule

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
   parameter int CNT_W = 8,
   parameter int LIMIT = 150
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (inc && (cnt != LIM_V)) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/amp_seq_fsm.sv
module amp_seq_fsm
   import amp_seq_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int T_SW  = 100,
   parameter int T_AUD = 50
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode_req,
   input  logic             tick,
   input  logic             short_any,
   input  logic [CNT_W-1:0] cnt,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output logic             sw_en,
   output logic             audio_en,
   output logic             standby_ind
);
   localparam int               T_MUTE  = T_SW + T_AUD;
   localparam logic [CNT_W-1:0] SW_LAST = CNT_W'(T_SW - 1);
   localparam logic [CNT_W-1:0] MUTE_V  = CNT_W'(T_MUTE);

   seq_state_t state, state_nx;

   always_comb begin
      state_nx = state;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      if (req_is_stby(mode_req)) begin
         state_nx = SEQ_IDLE;
         cnt_clr  = 1'b1;
      end else begin
         case (state)
            SEQ_IDLE: begin
               state_nx = SEQ_ARM;
               cnt_clr  = 1'b1;
            end
            SEQ_ARM: begin
               cnt_inc = tick && !short_any;
               if (cnt_inc && (cnt == SW_LAST)) begin
                  state_nx = SEQ_MUTED;
               end
            end
            SEQ_MUTED: begin
               cnt_inc = tick;
               if (req_is_oper(mode_req) && (cnt >= MUTE_V)) begin
                  state_nx = SEQ_LIVE;
               end
            end
            default: begin
               if (!req_is_oper(mode_req)) begin
                  state_nx = SEQ_MUTED;
                  cnt_clr  = 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SEQ_IDLE;
      end else begin
         state <= state_nx;
      end
   end

   assign sw_en       = (state == SEQ_MUTED) || (state == SEQ_LIVE);
   assign audio_en    = (state == SEQ_LIVE);
   assign standby_ind = (state == SEQ_IDLE);

endmodule

// File: rtl/amp_seq.sv
module amp_seq #(
   parameter int NOUT        = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8,
   parameter int T_SW        = 100,
   parameter int T_AUD       = 50
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode_req,
   input  logic              tick,
   input  logic [2*NOUT-1:0] short_flags,
   output logic              sw_en,
   output logic              audio_en,
   output logic              standby_ind
);
   localparam int T_MUTE = T_SW + T_AUD;

   generate
      if (NOUT < 1) begin : g_bad_nout
         $error("NOUT must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (T_SW < 1 || T_AUD < 0) begin : g_bad_dly
         $error("T_SW must be at least 1 and T_AUD non-negative");
      end
      if (CNT_W < 8 || T_MUTE >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W must be at least 8 and hold T_SW+T_AUD");
      end
   endgenerate

   logic             short_any;
   logic             tmr_clr;
   logic             tmr_inc;
   logic [CNT_W-1:0] tmr_cnt;

   amp_seq_shortmon #(
      .NOUT        (NOUT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_shortmon (
      .clk       (clk),
      .rst       (rst),
      .flags     (short_flags),
      .short_any (short_any)
   );

   amp_seq_timer #(
      .CNT_W (CNT_W),
      .LIMIT (T_MUTE)
   ) u_timer (
      .clk (clk),
      .rst (rst),
      .clr (tmr_clr),
      .inc (tmr_inc),
      .cnt (tmr_cnt)
   );

   amp_seq_fsm #(
      .CNT_W (CNT_W),
      .T_SW  (T_SW),
      .T_AUD (T_AUD)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .mode_req    (mode_req),
      .tick        (tick),
      .short_any   (short_any),
      .cnt         (tmr_cnt),
      .cnt_clr     (tmr_clr),
      .cnt_inc     (tmr_inc),
      .sw_en       (sw_en),
      .audio_en    (audio_en),
      .standby_ind (standby_ind)
   );

endmodule

// File: rtl/amp_seq_chk.sv
module amp_seq_chk #(
   parameter int NOUT  = 2,
   parameter int CNT_W = 8,
   parameter int T_SW  = 100,
   parameter int T_AUD = 50
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        mode_req,
   input logic              tick,
   input logic [2*NOUT-1:0] short_flags,
   input logic              sw_en,
   input logic              audio_en,
   input logic              standby_ind,
   input logic [CNT_W-1:0]  cnt
);
   localparam logic [CNT_W-1:0] MUTE_V = CNT_W'(T_SW + T_AUD);

   // R9: a standby request shuts everything off one clock later
   p_stby_off_r9: assert property (@(posedge clk) disable iff (rst)
      (mode_req == 2'b00) |=> (!sw_en && !audio_en && standby_ind));

   // R2: a non-standby request leaves standby one clock later
   p_leave_stby_r2: assert property (@(posedge clk) disable iff (rst)
      (standby_ind && mode_req != 2'b00) |=> !standby_ind);

   // R10: audio never runs without switching
   p_audio_sw_r10: assert property (@(posedge clk) disable iff (rst)
      audio_en |-> sw_en);

   // R8: a mute request drops audio and keeps switching
   p_mute_drop_r8: assert property (@(posedge clk) disable iff (rst)
      (audio_en && mode_req == 2'b01) |=> (!audio_en && sw_en));

   // R5: once switching, the short flags cannot stop it
   p_run_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (sw_en && mode_req != 2'b00 && short_flags != '0) |=> sw_en);

   // R3: switching starts only on a tick
   p_sw_rise_tick_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(sw_en) |-> $past(tick));

   // R6: audio starts only under operate with the mute time met
   p_audio_oper_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(audio_en) |-> ($past(mode_req[1]) && $past(cnt) == MUTE_V));

   // R11: the counter never passes its limit
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
      cnt <= MUTE_V);

endmodule

bind amp_seq amp_seq_chk #(
   .NOUT  (NOUT),
   .CNT_W (CNT_W),
   .T_SW  (T_SW),
   .T_AUD (T_AUD)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .mode_req    (mode_req),
   .tick        (tick),
   .short_flags (short_flags),
   .sw_en       (sw_en),
   .audio_en    (audio_en),
   .standby_ind (standby_ind),
   .cnt         (tmr_cnt)
);

// File: tb/amp_seq_test.sv
module amp_seq_test;
   localparam int NOUT   = 2;
   localparam int SYNC   = 2;
   localparam int T_SW   = 6;
   localparam int T_AUD  = 3;
   localparam int T_MUTE = T_SW + T_AUD;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [1:0]        mode_req = 2'b00;
   logic              tick = 1'b0;
   logic [2*NOUT-1:0] short_flags = '0;
   logic              sw_en, audio_en, standby_ind;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   amp_seq #(
      .NOUT(NOUT), .SYNC_STAGES(SYNC), .CNT_W(8), .T_SW(T_SW), .T_AUD(T_AUD)
   ) uut (
      .clk(clk), .rst(rst), .mode_req(mode_req), .tick(tick),
      .short_flags(short_flags), .sw_en(sw_en), .audio_en(audio_en),
      .standby_ind(standby_ind)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic go_stby();
      mode_req = 2'b00;
      short_flags = '0;
      cyc(SYNC + 2);
   endtask

   initial begin
      cyc(3);
      rst = 1'b0;
      cyc(1);
      // R1: reset state
      chk("R1 sw", sw_en, 1'b0);
      chk("R1 audio", audio_en, 1'b0);
      chk("R1 stby", standby_ind, 1'b1);
      // R2: ticks in standby do not count
      do_tick(T_SW + 2);
      chk("R2 stays stby", standby_ind, 1'b1);

      // R3 R4: sweep short position and flag bit
      for (int pos = 0; pos < T_SW; pos++) begin
         for (int b = 0; b < 2 * NOUT; b++) begin
            go_stby();
            mode_req = 2'b01;
            cyc(1);
            chk("R2 leave stby", standby_ind, 1'b0);
            do_tick(pos);
            short_flags[b] = 1'b1;
            cyc(SYNC + 1);
            do_tick(2);
            short_flags = '0;
            cyc(SYNC + 1);
            chk("R4 stalled", sw_en, 1'b0);
            if (T_SW - pos - 1 > 0) begin
               do_tick(T_SW - pos - 1);
               chk("R3 before last tick", sw_en, 1'b0);
            end
            do_tick(1);
            chk("R3 sw on last tick", sw_en, 1'b1);
            chk("R3 audio held", audio_en, 1'b0);
         end
      end

      // R6: sweep mute hold length before operate
      for (int m = 0; m <= T_MUTE + 2; m++) begin
         go_stby();
         mode_req = 2'b01;
         cyc(1);
         do_tick(m);
         chk("R3 sw after m ticks", sw_en, (m >= T_SW));
         mode_req = 2'b10;
         if (m >= T_MUTE) begin
            cyc(1);
            chk("R6 late operate", audio_en, 1'b1);
         end else begin
            if (T_MUTE - m - 1 > 0) do_tick(T_MUTE - m - 1);
            cyc(1);
            chk("R6 early", audio_en, 1'b0);
            do_tick(1);
            cyc(1);
            chk("R6 release", audio_en, 1'b1);
         end
      end

      // R7: direct standby to operate (mode 11 also operate)
      for (int v = 2; v < 4; v++) begin
         go_stby();
         mode_req = 2'(v);
         cyc(1);
         do_tick(T_SW - 1);
         chk("R7 sw off", sw_en, 1'b0);
         do_tick(1);
         chk("R7 sw on", sw_en, 1'b1);
         do_tick(T_AUD - 1);
         cyc(1);
         chk("R7 audio off", audio_en, 1'b0);
         do_tick(1);
         cyc(1);
         chk("R7 audio on", audio_en, 1'b1);
      end

      // R5: shorts ignored while playing
      short_flags = '1;
      cyc(SYNC + 1);
      do_tick(3);
      chk("R5 sw kept", sw_en, 1'b1);
      chk("R5 audio kept", audio_en, 1'b1);
      short_flags = '0;

      // R8: back to mute, timer restart
      mode_req = 2'b01;
      cyc(1);
      chk("R8 audio off", audio_en, 1'b0);
      chk("R8 sw kept", sw_en, 1'b1);
      mode_req = 2'b10;
      do_tick(T_MUTE - 1);
      cyc(1);
      chk("R8 wait mute min", audio_en, 1'b0);
      do_tick(1);
      cyc(1);
      chk("R8 release", audio_en, 1'b1);

      // R9: standby from playing, then from start-up
      mode_req = 2'b00;
      cyc(1);
      chk("R9 sw off", sw_en, 1'b0);
      chk("R9 audio off", audio_en, 1'b0);
      chk("R9 stby", standby_ind, 1'b1);
      mode_req = 2'b01;
      cyc(1);
      do_tick(T_SW - 1);
      mode_req = 2'b00;
      cyc(1);
      mode_req = 2'b01;
      cyc(1);
      do_tick(1);
      chk("R9 count reset", sw_en, 1'b0);
      do_tick(T_SW - 1);
      chk("R9 full delay again", sw_en, 1'b1);
      // R11: long mute, counter saturates, operate still releases
      do_tick(300);
      mode_req = 2'b10;
      cyc(1);
      chk("R11 saturated release", audio_en, 1'b1);
      chk("R10 sw with audio", sw_en, 1'b1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule